// File: doc/BRIEF.md
# Eight-Channel PWM Generator with Shared Timebases

This block produces eight pulse-width-modulated outputs from the system clock. Output frequency is not set per channel. Instead there are four timebases. Each timebase has a divisor counter that emits one tick every D clock cycles, and an 8-bit phase counter that advances on every tick. A full output period is therefore 256·D clock cycles: a divisor of 7910 at 202.5 MHz gives 100 Hz. Each channel picks one of the four timebases and compares that phase against its own 8-bit duty value. The output is high while the phase is below the duty.

Software programs the block through a synchronous write port and a combinational read port. The port uses word addresses:

| Address | Register |
|---|---|
| 0 | channel control: enables in bits 7:0, bypass bits in 15:8 |
| 1 | timebase control: run enables in bits 3:0, sync-off bits in 11:8 |
| 2–5 | divisors 0–3 |
| 6–13 | channel configurations 0–7 |

A channel's configuration takes effect glitch-free. It reaches the comparator only at the wrap of its timebase, or at once while that timebase is stopped. Clearing a timebase's sync-off bit makes every configuration write that selects that timebase restart its phase. This aligns all channels that share the timebase.

Top module: `pwm_octet`

## Requirements
- R1: After reset the registers read as follows: channel control 0x0001 (only channel 0 enabled), timebase control 0x0F01 (timebase 0 running, all sync-off bits set), every divisor 0x000A, and every channel configuration 0x0001 (timebase 0, duty 1).
- R2: Unimplemented bits read as zero. Writing 0xFFFF to timebase control reads back 0x0F0F, and writing it to a configuration reads back 0x03FF.
- R3: A running timebase with divisor D advances its phase by one every D cycles and wraps from 255 to 0, so the period is 256·D cycles. A divisor of 0 behaves as 1.
- R4: An enabled, non-bypassed channel is high exactly while its selected phase is below its duty (configuration bits 7:0). A duty of 0 gives a constant low.
- R5: A channel whose enable bit is 0 drives 0, even when its bypass bit is set.
- R6: An enabled channel whose bypass bit is set drives a constant 1, whatever its duty.
- R7: A timebase whose run bit is 0 holds its divisor and phase counters at zero.
- R8: Configuration bits 9:8 select the timebase (0 to 3) that the channel compares against.
- R9: A new duty or select value reaches the comparator only when the newly selected timebase wraps from 255 to 0, or on the next cycle while that timebase is stopped.
- R10: While a timebase's sync-off bit is 0, a configuration write that selects it zeroes that timebase's phase at the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| addr | input | 4 | Word address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| pwm_out | output | 8 | Channel outputs, bit n for channel n |

## Verification
A phase counter that skips, stalls or fails to clear shows up as a shifted edge on every channel that shares that timebase. With a divisor of 1 the shift is visible within one cycle of the fault. A shadow register that loads at the wrong time shows a duty change in the same period as the write, instead of one period later. A wrong sync or idle-hold shows as an output level that differs from the phase position counted from a known restart. Stimulus therefore restarts each timebase at a known edge, then samples the outputs at chosen phases on either side of the duty threshold.

// File: rtl/pwm_octet_pkg.sv
package pwm_octet_pkg;
   localparam int unsigned ADR_CTRL    = 0;
   localparam int unsigned ADR_TBCTRL  = 1;
   localparam int unsigned ADR_DIV0    = 2;
   localparam int unsigned BYP_LSB     = 8;
   localparam int unsigned SYNC_LSB    = 8;
   localparam int unsigned SEL_LSB     = 8;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pwm_octet_regs.sv
module pwm_octet_regs
   import pwm_octet_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_TB  = 4,
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned DUTY_W  = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 4,
   parameter logic [DIV_W-1:0] DIV_RST = 'h000A,
   localparam int unsigned SEL_W  = sel_width(NUM_TB)
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [DATA_W-1:0]         rdata,
   output logic [NUM_CH-1:0]         ch_en,
   output logic [NUM_CH-1:0]         ch_byp,
   output logic [NUM_TB-1:0]         tb_en,
   output logic [NUM_TB-1:0]         tb_sync,
   output logic [NUM_TB*DIV_W-1:0]   div_flat,
   output logic [NUM_CH*SEL_W-1:0]   sel_flat,
   output logic [NUM_CH*DUTY_W-1:0]  duty_flat
);
   localparam int unsigned CFG0 = ADR_DIV0 + NUM_TB;

   logic [NUM_CH-1:0] en_q, byp_q;
   logic [NUM_TB-1:0] run_q, soff_q;
   logic [DIV_W-1:0]  div_q  [NUM_TB];
   logic [SEL_W-1:0]  sel_q  [NUM_CH];
   logic [DUTY_W-1:0] duty_q [NUM_CH];
   logic              cfg_hit;
   logic [SEL_W-1:0]  new_sel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= NUM_CH'(1);
         byp_q  <= '0;
         run_q  <= NUM_TB'(1);
         soff_q <= '1;
         for (int t = 0; t < NUM_TB; t++) div_q[t] <= DIV_RST;
         for (int c = 0; c < NUM_CH; c++) begin
            sel_q[c]  <= '0;
            duty_q[c] <= DUTY_W'(1);
         end
      end else if (wr_en) begin
         if (addr == ADDR_W'(ADR_CTRL)) begin
            en_q  <= wdata[NUM_CH-1:0];
            byp_q <= wdata[BYP_LSB +: NUM_CH];
         end
         if (addr == ADDR_W'(ADR_TBCTRL)) begin
            run_q  <= wdata[NUM_TB-1:0];
            soff_q <= wdata[SYNC_LSB +: NUM_TB];
         end
         for (int t = 0; t < NUM_TB; t++)
            if (addr == ADDR_W'(ADR_DIV0 + t)) div_q[t] <= wdata[DIV_W-1:0];
         for (int c = 0; c < NUM_CH; c++)
            if (addr == ADDR_W'(CFG0 + c)) begin
               sel_q[c]  <= wdata[SEL_LSB +: SEL_W];
               duty_q[c] <= wdata[DUTY_W-1:0];
            end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(ADR_CTRL)) begin
         rdata[NUM_CH-1:0]        = en_q;
         rdata[BYP_LSB +: NUM_CH] = byp_q;
      end
      if (addr == ADDR_W'(ADR_TBCTRL)) begin
         rdata[NUM_TB-1:0]         = run_q;
         rdata[SYNC_LSB +: NUM_TB] = soff_q;
      end
      for (int t = 0; t < NUM_TB; t++)
         if (addr == ADDR_W'(ADR_DIV0 + t)) rdata[DIV_W-1:0] = div_q[t];
      for (int c = 0; c < NUM_CH; c++)
         if (addr == ADDR_W'(CFG0 + c)) begin
            rdata[DUTY_W-1:0]       = duty_q[c];
            rdata[SEL_LSB +: SEL_W] = sel_q[c];
         end
   end

   // a configuration write restarts the timebase it selects when sync is on
   always_comb begin
      cfg_hit = 1'b0;
      for (int c = 0; c < NUM_CH; c++)
         if (addr == ADDR_W'(CFG0 + c)) cfg_hit = wr_en;
      new_sel = wdata[SEL_LSB +: SEL_W];
      for (int t = 0; t < NUM_TB; t++)
         tb_sync[t] = cfg_hit && (new_sel == SEL_W'(t)) && !soff_q[t];
   end

   assign ch_en  = en_q;
   assign ch_byp = byp_q;
   assign tb_en  = run_q;

   generate
      for (genvar t = 0; t < NUM_TB; t++) begin : g_div
         assign div_flat[t*DIV_W +: DIV_W] = div_q[t];
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
         assign sel_flat[c*SEL_W +: SEL_W]    = sel_q[c];
         assign duty_flat[c*DUTY_W +: DUTY_W] = duty_q[c];
      end
   endgenerate
endmodule

// File: rtl/pwm_octet_tb.sv
module pwm_octet_tb #(
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned PHASE_W = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cnt_en,
   input  logic               sync_clr,
   input  logic [DIV_W-1:0]   div,
   output logic [PHASE_W-1:0] phase,
   output logic               wrap
);
   logic [DIV_W-1:0]   cnt_q;
   logic [DIV_W-1:0]   last;
   logic [PHASE_W-1:0] phase_q;
   logic               tick;

   assign last = (div == '0) ? '0 : div - DIV_W'(1);
   assign tick = (cnt_q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n || !cnt_en || sync_clr) begin
         cnt_q   <= '0;
         phase_q <= '0;
      end else if (tick) begin
         cnt_q   <= '0;
         phase_q <= phase_q + PHASE_W'(1);
      end else begin
         cnt_q   <= cnt_q + DIV_W'(1);
      end
   end

   assign phase = phase_q;
   assign wrap  = cnt_en && !sync_clr && tick && (phase_q == '1);
endmodule

// File: rtl/pwm_octet_ch.sv
module pwm_octet_ch #(
   parameter int unsigned NUM_TB  = 4,
   parameter int unsigned PHASE_W = 8,
   parameter int unsigned SEL_W   = 2
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic                      byp,
   input  logic [SEL_W-1:0]          cfg_sel,
   input  logic [PHASE_W-1:0]        cfg_duty,
   input  logic [NUM_TB*PHASE_W-1:0] tb_phase,
   input  logic [NUM_TB-1:0]         tb_wrap,
   input  logic [NUM_TB-1:0]         tb_run,
   output logic                      pwm
);
   logic [SEL_W-1:0]   sh_sel;
   logic [PHASE_W-1:0] sh_duty;
   logic [PHASE_W-1:0] cur_phase;
   logic               load;

   assign load = tb_wrap[cfg_sel] || !tb_run[cfg_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_sel  <= '0;
         sh_duty <= PHASE_W'(1);
      end else if (load) begin
         sh_sel  <= cfg_sel;
         sh_duty <= cfg_duty;
      end
   end

   assign cur_phase = tb_phase[sh_sel*PHASE_W +: PHASE_W];
   assign pwm       = en && (byp || (cur_phase < sh_duty));
endmodule

// File: rtl/pwm_octet.sv
module pwm_octet
   import pwm_octet_pkg::*;
#(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_TB  = 4,
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned PHASE_W = 8,
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned ADDR_W  = 4,
   parameter logic [DIV_W-1:0] DIV_RST = 'h000A,
   parameter bit          OUT_REG = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int unsigned SEL_W   = sel_width(NUM_TB);
   localparam int unsigned N_WORDS = ADR_DIV0 + NUM_TB + NUM_CH;

   generate
      if (NUM_CH < 1 || BYP_LSB + NUM_CH > DATA_W) begin : g_bad_ch
         $error("pwm_octet: NUM_CH does not fit the channel control word");
      end
      if (NUM_TB < 1 || SYNC_LSB + NUM_TB > DATA_W || NUM_TB > SYNC_LSB) begin : g_bad_tb
         $error("pwm_octet: NUM_TB does not fit the timebase control word");
      end
      if (DIV_W > DATA_W || PHASE_W > SEL_LSB || SEL_LSB + SEL_W > DATA_W) begin : g_bad_w
         $error("pwm_octet: field widths exceed the data word");
      end
      if (N_WORDS > (1 << ADDR_W)) begin : g_bad_a
         $error("pwm_octet: ADDR_W too small for the register words");
      end
   endgenerate

   logic [NUM_CH-1:0]          ch_en, ch_byp, pwm_raw;
   logic [NUM_TB-1:0]          tb_en, tb_sync, tb_wrap;
   logic [NUM_TB*DIV_W-1:0]    div_flat;
   logic [NUM_TB*PHASE_W-1:0]  tb_phase_flat;
   logic [NUM_CH*SEL_W-1:0]    sel_flat;
   logic [NUM_CH*PHASE_W-1:0]  duty_flat;

   pwm_octet_regs #(
      .NUM_CH (NUM_CH), .NUM_TB (NUM_TB), .DIV_W (DIV_W), .DUTY_W (PHASE_W),
      .DATA_W (DATA_W), .ADDR_W (ADDR_W), .DIV_RST (DIV_RST)
   ) u_regs (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr), .wdata (wdata),
      .rdata (rdata), .ch_en (ch_en), .ch_byp (ch_byp), .tb_en (tb_en),
      .tb_sync (tb_sync), .div_flat (div_flat), .sel_flat (sel_flat),
      .duty_flat (duty_flat)
   );

   generate
      for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
         pwm_octet_tb #(.DIV_W (DIV_W), .PHASE_W (PHASE_W)) u_tb (
            .clk (clk), .rst_n (rst_n), .cnt_en (tb_en[t]), .sync_clr (tb_sync[t]),
            .div (div_flat[t*DIV_W +: DIV_W]),
            .phase (tb_phase_flat[t*PHASE_W +: PHASE_W]), .wrap (tb_wrap[t])
         );
      end

      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         pwm_octet_ch #(.NUM_TB (NUM_TB), .PHASE_W (PHASE_W), .SEL_W (SEL_W)) u_ch (
            .clk (clk), .rst_n (rst_n), .en (ch_en[c]), .byp (ch_byp[c]),
            .cfg_sel (sel_flat[c*SEL_W +: SEL_W]),
            .cfg_duty (duty_flat[c*PHASE_W +: PHASE_W]),
            .tb_phase (tb_phase_flat), .tb_wrap (tb_wrap), .tb_run (tb_en),
            .pwm (pwm_raw[c])
         );
      end

      if (OUT_REG) begin : g_oreg
         logic [NUM_CH-1:0] out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= pwm_raw;
         end
         assign pwm_out = out_q;
      end else begin : g_ocomb
         assign pwm_out = pwm_raw;
      end
   endgenerate
endmodule

// File: rtl/pwm_octet_chk.sv
module pwm_octet_chk #(
   parameter int unsigned NUM_CH  = 8,
   parameter int unsigned NUM_TB  = 4,
   parameter int unsigned PHASE_W = 8,
   parameter bit          OUT_REG = 1'b0
)(
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_CH-1:0]         pwm_out,
   input logic [NUM_CH-1:0]         ch_en,
   input logic [NUM_CH-1:0]         ch_byp,
   input logic [NUM_TB-1:0]         tb_en,
   input logic [NUM_TB-1:0]         tb_sync,
   input logic [NUM_TB*PHASE_W-1:0] tb_phase_flat
);
   generate
      if (!OUT_REG) begin : g_comb
         assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_out & ~ch_en) == '0);
         assert_bypass_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pwm_out & ch_en & ch_byp) == (ch_en & ch_byp));
      end

      for (genvar t = 0; t < NUM_TB; t++) begin : g_tb
         assert_phase_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (tb_phase_flat[t*PHASE_W +: PHASE_W] != $past(tb_phase_flat[t*PHASE_W +: PHASE_W]))
            |-> ((tb_phase_flat[t*PHASE_W +: PHASE_W]
                  == $past(tb_phase_flat[t*PHASE_W +: PHASE_W]) + PHASE_W'(1))
                 || (tb_phase_flat[t*PHASE_W +: PHASE_W] == '0)));
         assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !tb_en[t] |=> (tb_phase_flat[t*PHASE_W +: PHASE_W] == '0));
         assert_sync_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
            tb_sync[t] |=> (tb_phase_flat[t*PHASE_W +: PHASE_W] == '0));
      end
   endgenerate
endmodule

bind pwm_octet pwm_octet_chk #(
   .NUM_CH (NUM_CH), .NUM_TB (NUM_TB), .PHASE_W (PHASE_W), .OUT_REG (OUT_REG)
) u_chk (
   .clk (clk), .rst_n (rst_n), .pwm_out (pwm_out), .ch_en (ch_en), .ch_byp (ch_byp),
   .tb_en (tb_en), .tb_sync (tb_sync), .tb_phase_flat (tb_phase_flat)
);

// File: tb/test_pwm_octet.sv
module test_pwm_octet;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [7:0]  pwm_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_octet i_pwm_octet (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
      .wdata (wdata), .rdata (rdata), .pwm_out (pwm_out)
   );

   typedef struct packed {
      logic [2:0]  ch;
      logic [1:0]  tb;
      logic [15:0] div;
      logic [7:0]  duty;
      logic [9:0]  k;
      logic        exp;
   } vec_t;

   // expected level = (floor(k/max(div,1)) mod 256) < duty
   localparam vec_t VECS [11] = '{
      '{3'd0, 2'd0, 16'd1, 8'd128, 10'd100, 1'b1},
      '{3'd0, 2'd0, 16'd1, 8'd128, 10'd200, 1'b0},
      '{3'd3, 2'd2, 16'd4, 8'd10,  10'd39,  1'b1},
      '{3'd3, 2'd2, 16'd4, 8'd10,  10'd40,  1'b0},
      '{3'd5, 2'd1, 16'd0, 8'd255, 10'd254, 1'b1},
      '{3'd5, 2'd1, 16'd0, 8'd255, 10'd255, 1'b0},
      '{3'd7, 2'd3, 16'd2, 8'd1,   10'd1,   1'b1},
      '{3'd7, 2'd3, 16'd2, 8'd1,   10'd2,   1'b0},
      '{3'd2, 2'd0, 16'd1, 8'd0,   10'd5,   1'b0},
      '{3'd6, 2'd1, 16'd3, 8'd200, 10'd300, 1'b1},
      '{3'd1, 2'd0, 16'd1, 8'd50,  10'd256, 1'b1}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [3:0] a, input logic [15:0] exp);
      @(negedge clk);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   // stop all timebases, load divisor and channel, enable it, then start the timebase
   task automatic arm(input int ch, input int tb, input logic [15:0] div,
                      input logic [7:0] duty, input logic [15:0] tbctrl_run);
      wr(4'd1, 16'h0F00);
      wr(4'(2 + tb), div);
      wr(4'(6 + ch), {6'd0, 2'(tb), duty});
      wr(4'd0, 16'(1 << ch));
      wr(4'd1, tbctrl_run);
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      run(3);
      rst_n = 1'b1;
      // R1: reset state and reset register values
      chk("R1 reset outputs", {8'd0, pwm_out}, 16'h0001);
      rd_chk("R1 ctrl reset", 4'd0, 16'h0001);
      rd_chk("R1 tbctrl reset", 4'd1, 16'h0F01);
      for (int t = 0; t < 4; t++) rd_chk("R1 divisor reset", 4'(2 + t), 16'h000A);
      rd_chk("R1 cfg0 reset", 4'd6, 16'h0001);
      rd_chk("R1 cfg7 reset", 4'd13, 16'h0001);

      // R2: unimplemented bits read zero
      wr(4'd1, 16'hFFFF);
      rd_chk("R2 tbctrl mask", 4'd1, 16'h0F0F);
      wr(4'd9, 16'hFFFF);
      rd_chk("R2 cfg mask", 4'd9, 16'h03FF);
      wr(4'd9, 16'h0233);
      rd_chk("R8 cfg select readback", 4'd9, 16'h0233);

      // vector table: R3 period, R4 compare, R8 timebase select
      foreach (VECS[i]) begin
         arm(VECS[i].ch, VECS[i].tb, VECS[i].div, VECS[i].duty,
             16'h0F00 | 16'(1 << VECS[i].tb));
         run(VECS[i].k);
         chk($sformatf("R3/R4/R8 vector %0d", i), {8'd0, pwm_out},
             {8'd0, 8'(VECS[i].exp) << VECS[i].ch});
      end

      // R7: stopped timebase holds phase 0, so duty 5 stays high
      wr(4'd1, 16'h0F00);
      wr(4'd7, 16'h0105);
      wr(4'd0, 16'h0002);
      run(600);
      chk("R7 stopped timebase holds", {8'd0, pwm_out}, 16'h0002);

      // R6 / R5 / R4 with duty 0 on channel 4
      wr(4'd10, 16'h0000);
      wr(4'd0, 16'h1010);
      run(2);
      chk("R6 bypass forces high", {8'd0, pwm_out}, 16'h0010);
      wr(4'd0, 16'h1000);
      run(2);
      chk("R5 disabled beats bypass", {8'd0, pwm_out}, 16'h0000);
      wr(4'd0, 16'h0010);
      run(2);
      chk("R4 duty zero low", {8'd0, pwm_out}, 16'h0000);

      // R9: mid-period duty change waits for the wrap
      arm(0, 0, 16'd1, 8'd10, 16'h0F01);
      run(50);
      wr(4'd6, 16'h00C8);
      run(49);
      chk("R9 old duty before wrap", {8'd0, pwm_out}, 16'h0000);
      run(256);
      chk("R9 new duty after wrap", {8'd0, pwm_out}, 16'h0001);

      // R10: sync on restarts the phase at the config write
      arm(0, 0, 16'd1, 8'd100, 16'h0E01);
      run(150);
      chk("R10 before sync", {8'd0, pwm_out}, 16'h0000);
      wr(4'd6, 16'h0064);
      run(20);
      chk("R10 sync restarts phase", {8'd0, pwm_out}, 16'h0001);
      arm(0, 0, 16'd1, 8'd100, 16'h0F01);
      run(150);
      wr(4'd6, 16'h0064);
      run(20);
      chk("R10 sync off keeps phase", {8'd0, pwm_out}, 16'h0000);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule